// File: doc/BRIEF.md
# Parallel EPROM Read Sequencer

This block turns single-cycle host read requests into correctly timed read cycles on an asynchronous byte-wide nonvolatile memory. The memory has a 16-bit address bus, an 8-bit data bus, an active-low chip enable and an active-low output enable. All memory timing limits are given to the block as clock-cycle counts: address-to-data, enable-to-data, enable-to-output-enable setup, output-enable-to-data and output float time. Each count is the memory's limit divided by the clock period and rounded up.

A host raises `req_i` with an address and keeps both steady until `rdy_o` pulses. The block drives the address and chip enable together. After the setup count it lowers output enable. It captures the data bus on the first clock edge by which all three access delays have run out. It then raises both enables, pulses `rdy_o` for one cycle with the byte, and refuses new work until the float count has passed.

With `ident_i` set, the access becomes a signature read. A separate high-voltage select output goes high for the whole access, and only address bit 0 is driven. With bit 0 low the memory answers with its maker code 0xDA; with bit 0 high it answers with its device code 0x08.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: During and just after reset, `rdy_o` is 0, `mem_ce_n_o` and `mem_oe_n_o` are 1 and `mem_hv_sel_o` is 0.
- R2: On the edge where an idle block sees `req_i` high, `mem_ce_n_o` falls and the address is driven. The address stays unchanged while `mem_ce_n_o` is low, and chip enable stays low for exactly SAMPLE_CYC cycles. SAMPLE_CYC is the largest of ADDR_CYC, CE_CYC and SETUP_CYC+OE_CYC.
- R3: `mem_oe_n_o` is never low while `mem_ce_n_o` is high. It falls SETUP_CYC cycles after chip enable falls and stays low for SAMPLE_CYC−SETUP_CYC cycles.
- R4: The data bus is captured on the edge SAMPLE_CYC cycles after the accepting edge. `rdy_o` is high for exactly one cycle with `rdata_o` equal to the captured byte, so a request from idle completes SAMPLE_CYC+1 cycles after `req_i` is first presented.
- R5: On the capture edge both enables return high.
- R6: After output enable rises, chip enable stays high for at least FLOAT_CYC+1 cycles. A request that waits during the float time is accepted only after that time has passed.
- R7: In signature mode (`ident_i`=1 at acceptance), `mem_hv_sel_o` is 1 for the whole access and `mem_addr_o` is `addr_i[0]` with every other bit 0. The returned byte is 0xDA for bit 0 low and 0x08 for bit 0 high.
- R8: In normal mode, `mem_hv_sel_o` stays 0 and `mem_addr_o` equals the full `addr_i`.
- R9: Changes of `addr_i` after acceptance have no effect on `mem_addr_o` or on the returned byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Read request, held until `rdy_o` |
| addr_i | input | ADDR_W | Read address |
| ident_i | input | 1 | Select signature read |
| rdy_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | DATA_W | Captured byte |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_hv_sel_o | output | 1 | Request for high-voltage signature level on the identifier address line |
| mem_data_i | input | DATA_W | Memory data bus |

## Verification
Some rules hold on every cycle, and the inline properties cover these. They check that output enable stays inside chip enable, that the address is stable while chip enable is low, and that the ready strobe is a single cycle with both enables high. They also check that the float gap has passed before every chip-enable fall, and that the signature select is only ever seen with a bit-0-only address. Other behaviour can only be shown by a bench memory model that returns inverted data until every delay has elapsed. The scenarios use this model to show sampling on the right edge, the exact latency from idle and back-to-back, the signature codes, and the immunity to late address changes.

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int ADDR_CYC  = 6,
  parameter int CE_CYC    = 6,
  parameter int OE_CYC    = 3,
  parameter int SETUP_CYC = 1,
  parameter int FLOAT_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ident_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_hv_sel_o,
  input  logic [DATA_W-1:0] mem_data_i
);

  localparam int OE_PATH    = SETUP_CYC + OE_CYC;
  localparam int AC_MAX     = (ADDR_CYC > CE_CYC) ? ADDR_CYC : CE_CYC;
  localparam int SAMPLE_CYC = (AC_MAX > OE_PATH) ? AC_MAX : OE_PATH;
  localparam int CNT_MAX    = (SAMPLE_CYC > FLOAT_CYC) ? SAMPLE_CYC : FLOAT_CYC;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYC - 1);
  localparam logic [CNT_W-1:0] FLOAT_LAST  = CNT_W'(FLOAT_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_ACCESS, S_FLOAT} st_t;

  st_t              st_q;
  logic [CNT_W-1:0] cnt_q;

  wire [ADDR_W-1:0] id_addr = {{(ADDR_W-1){1'b0}}, addr_i[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= S_IDLE;
      cnt_q        <= '0;
      mem_ce_n_o   <= 1'b1;
      mem_oe_n_o   <= 1'b1;
      mem_addr_o   <= '0;
      mem_hv_sel_o <= 1'b0;
      rdy_o        <= 1'b0;
      rdata_o      <= '0;
    end else begin
      rdy_o <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (req_i) begin
            st_q         <= S_ACCESS;
            cnt_q        <= '0;
            mem_ce_n_o   <= 1'b0;
            mem_hv_sel_o <= ident_i;
            mem_addr_o   <= ident_i ? id_addr : addr_i;
          end
        end
        S_ACCESS: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == SETUP_LAST) mem_oe_n_o <= 1'b0;
          if (cnt_q == SAMPLE_LAST) begin
            rdata_o      <= mem_data_i;
            rdy_o        <= 1'b1;
            mem_ce_n_o   <= 1'b1;
            mem_oe_n_o   <= 1'b1;
            mem_hv_sel_o <= 1'b0;
            cnt_q        <= '0;
            st_q         <= S_FLOAT;
          end
        end
        S_FLOAT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == FLOAT_LAST) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  localparam int GAP_TOP = FLOAT_CYC + 1;
  localparam int GAP_W   = $clog2(GAP_TOP + 1);
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= GAP_W'(GAP_TOP);
    else if (!mem_oe_n_o)           gap_q <= '0;
    else if (gap_q < GAP_W'(GAP_TOP)) gap_q <= gap_q + 1'b1;
  end

  a_r3_oe_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n_o |-> !mem_ce_n_o);

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n_o && !$past(mem_ce_n_o)) |-> $stable(mem_addr_o));

  a_r4_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o);

  a_r5_enables_high: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> (mem_ce_n_o && mem_oe_n_o));

  a_r6_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n_o) |-> (gap_q >= GAP_W'(GAP_TOP)));

  a_r7_hv_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hv_sel_o |-> (!mem_ce_n_o && (mem_addr_o[ADDR_W-1:1] == '0)));

endmodule

// File: tb/eprom_rd_ctrl_tb_top.sv
module eprom_rd_ctrl_tb_top;
  localparam int AC = 6, CC = 6, OC = 3, SC = 1, FC = 3;
  localparam int S  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic ident_i = 1'b0;
  logic rdy_o, mem_ce_n, mem_oe_n, mem_hv;
  logic [7:0] rdata_o, mem_data;
  logic [15:0] mem_addr;

  int n_chk = 0, n_bad = 0, cyc = 0, last_lat = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  eprom_rd_ctrl #(.ADDR_W(16), .DATA_W(8), .ADDR_CYC(AC), .CE_CYC(CC),
                  .OE_CYC(OC), .SETUP_CYC(SC), .FLOAT_CYC(FC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
    .ident_i(ident_i), .rdy_o(rdy_o), .rdata_o(rdata_o),
    .mem_ce_n_o(mem_ce_n), .mem_oe_n_o(mem_oe_n), .mem_addr_o(mem_addr),
    .mem_hv_sel_o(mem_hv), .mem_data_i(mem_data));

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  logic [15:0] prev_addr = '0;
  int ad_age = 0, ce_age = 0, oe_age = 0;
  always @(negedge clk) begin
    ad_age    <= (mem_addr != prev_addr) ? 1 : ad_age + 1;
    prev_addr <= mem_addr;
    ce_age    <= mem_ce_n ? 0 : ce_age + 1;
    oe_age    <= mem_oe_n ? 0 : oe_age + 1;
  end
  wire [7:0] m_val = mem_hv ? (mem_addr[0] ? 8'h08 : 8'hDA) : pat(mem_addr);
  wire m_ok = !mem_ce_n && !mem_oe_n && ad_age >= AC && ce_age >= CC && oe_age >= OC;
  assign mem_data = m_ok ? m_val : ~m_val;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [15:0] a_late, input bit id);
    logic [7:0] exp = id ? (a[0] ? 8'h08 : 8'hDA) : pat(a);
    logic [15:0] ea = id ? {15'b0, a[0]} : a;
    int ce_lo = 0, oe_lo = 0, a_bad = 0, hv_bad = 0, n = 0;
    req_i = 1'b1; addr_i = a; ident_i = id;
    while (n < 200) begin
      @(negedge clk);
      n++;
      if (n == 3) addr_i = a_late;
      if (!mem_ce_n) ce_lo++;
      if (!mem_oe_n) oe_lo++;
      if (!mem_ce_n && mem_addr != ea) a_bad++;
      if (!mem_ce_n && mem_hv != id) hv_bad++;
      if (rdy_o) break;
    end
    req_i = 1'b0;
    last_lat = n;
    chk(rdata_o == exp, id ? "R7 ident byte" : "R4 read byte", rdata_o, exp);
    chk(ce_lo == S, "R2 ce low cycles", ce_lo, S);
    chk(oe_lo == S - SC, "R3 oe low cycles", oe_lo, S - SC);
    chk(a_bad == 0, id ? "R7 ident address" : "R8 address", a_bad, 0);
    chk(hv_bad == 0, id ? "R7 hv select" : "R8 hv low", hv_bad, 0);
    chk(mem_ce_n && mem_oe_n, "R5 enables high", {mem_ce_n, mem_oe_n}, 2'b11);
    @(negedge clk);
    chk(!rdy_o, "R4 rdy single cycle", rdy_o, 0);
    chk(!mem_hv, "R7 hv released", mem_hv, 0);
  endtask

  task automatic idle_gap();
    repeat (FC + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!rdy_o && mem_ce_n && mem_oe_n && !mem_hv, "R1 reset state",
        {rdy_o, mem_ce_n, mem_oe_n, mem_hv}, 4'b0110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && !rdy_o, "R1 idle after reset",
        {rdy_o, mem_ce_n, mem_oe_n}, 3'b011);
  endtask

  task automatic t_plain();
    foreach (addrs[i]) begin
      idle_gap();
      do_read(addrs[i], addrs[i], 1'b0);
      chk(last_lat == S + 1, "R4 latency from idle", last_lat, S + 1);
    end
  endtask
  logic [15:0] addrs [4] = '{16'h0000, 16'hFFFF, 16'h1234, 16'h8001};

  task automatic t_ident();
    idle_gap();
    do_read(16'h0200, 16'h0200, 1'b1);
    idle_gap();
    do_read(16'hFFFF, 16'hFFFF, 1'b1);
  endtask

  task automatic t_back_to_back();
    idle_gap();
    do_read(16'h00A5, 16'h00A5, 1'b0);
    do_read(16'h5A00, 16'h5A00, 1'b0);
    chk(last_lat == S + FC, "R6 held off by float", last_lat, S + FC);
  endtask

  task automatic t_late_addr();
    idle_gap();
    do_read(16'h4321, 16'hBEEF, 1'b0);
    chk(mem_addr == 16'h4321, "R9 address kept", mem_addr, 16'h4321);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc >= 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_ident();
    t_back_to_back();
    t_late_addr();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule